// File: doc/BRIEF.md
# Serial Path Overhead Insertion Port

This block lets logic outside the chip replace any of the nine path overhead bytes of an STS-1 synchronous payload envelope (J1, B3, C2, G1, F2, H4, Z3, Z4, Z5) before transmission. For every channel it generates a slow overhead clock from the system clock, plus two strobes. The frame strobe marks the start of the J1 byte. The byte strobe marks the start of each overhead byte. It samples a serial data pin and an insert-request pin bit by bit. For each byte it then presents either the value shifted in from outside or an internally supplied default, together with a flag that says which one was chosen.

All logic runs on the system clock. A clock-enable divider produces a falling phase and a rising phase. Strobes and the overhead clock change in the falling phase, and the serial inputs are sampled in the rising phase. Each strobe rises one overhead clock period before the first bit of its byte. The external logic drives the first bit on the next falling edge and each later bit on each falling edge after that, most significant bit first. A byte is taken from outside only when the insert request was high on all eight of its bits. A one-cycle valid pulse carries the nine results of each frame in order. A frame counter steps after the ninth byte. The timing is shared by all channels, while the strobes, clock pins, data capture and override decision are replicated for each channel.

Top module: `ohp_ins_port`

## Requirements
- R1: The overhead clock of every channel is low during reset and afterwards is high for DIV/2 system cycles and low for DIV/2 system cycles, repeating.
- R2: The byte strobe rises only on a falling edge of the overhead clock. It then stays high for exactly 8 overhead clock periods (8*DIV system cycles) and rises 9 times per frame, once per byte slot of BYTE_PERIOD overhead periods.
- R3: The frame strobe rises together with the byte strobe of the J1 byte (byte index 0) and nowhere else. It stays high for 8 overhead clock periods and is never high while the byte strobe is low.
- R4: Counting the falling edges after the one on which the byte strobe rose, the bit driven on falling edge k (k = 1..8) is sampled on the following rising edge and is bit 8-k of the byte, so the most significant bit comes first. The insert request is sampled on the same edges.
- R5: If the insert request was sampled high on all 8 bits of a byte, the byte output equals the assembled serial value and the override flag is 1.
- R6: If the insert request was sampled low on any of the 8 bits, the byte output equals the default input of that channel and the override flag is 0.
- R7: One system cycle after the rising edge that samples the eighth bit, the valid output pulses high for exactly one cycle. The byte index output then gives 0..8 for J1, B3, C2, G1, F2, H4, Z3, Z4, Z5. Byte outputs and flags change only on that cycle.
- R8: The frame counter increments by one, modulo 2^FCNT_W, in the same cycle as the valid pulse for byte index 8, and holds otherwise.
- R9: Channels are independent: the override decision and byte value of one channel depend only on that channel's insert, data and default inputs. The strobes and clock of every channel carry the same timing.
- R10: During reset all strobes, overhead clocks, override flags, byte outputs, the valid output, the byte index and the frame counter are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_i | input | NUM_CH | Insert request, one bit per channel |
| din_i | input | NUM_CH | Serial overhead data, one bit per channel |
| def_i | input | 8*NUM_CH | Default overhead byte per channel, channel c at bits 8c+7..8c |
| oh_clk_o | output | NUM_CH | Overhead clock per channel |
| oh_frame_o | output | NUM_CH | Frame strobe per channel (J1 start) |
| oh_en_o | output | NUM_CH | Byte strobe per channel |
| byte_o | output | 8*NUM_CH | Selected overhead byte per channel, same packing as def_i |
| ovr_o | output | NUM_CH | Override flag per channel (1 = external value used) |
| valid_o | output | 1 | One-cycle pulse when a byte result is presented |
| sel_o | output | 4 | Index of the presented byte, 0 = J1 through 8 = Z5 |
| frame_cnt_o | output | FCNT_W | Count of completed frames |

## Verification
The assertions assume that the insert and data inputs change only in the falling phase of the overhead clock, so each value is stable at the rising-phase sample that follows, and that reset is held for at least one clock edge. The bench keeps to this rule by watching the overhead clock at the falling system edge. It updates the serial inputs only on a detected overhead falling edge and derives the bit number from the falling edges counted since the byte strobe rose. The defaults are loaded at the strobe edge, well before the byte completes, so the default input is stable when the choice is made.

// File: rtl/ohp_pkg.sv
package ohp_pkg;
  localparam int POH_BYTES     = 9;
  localparam int BITS_PER_BYTE = 8;
  localparam int SEL_W         = 4;

  typedef enum logic [SEL_W-1:0] {
    POH_J1 = 4'd0,
    POH_B3 = 4'd1,
    POH_C2 = 4'd2,
    POH_G1 = 4'd3,
    POH_F2 = 4'd4,
    POH_H4 = 4'd5,
    POH_Z3 = 4'd6,
    POH_Z4 = 4'd7,
    POH_Z5 = 4'd8
  } poh_sel_e;
endpackage

// File: rtl/ohp_clkdiv.sv
module ohp_clkdiv #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic fall_en,
  output logic rise_en
);
  localparam int DIV_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] HALF_M1 = DIV_W'(DIV / 2 - 1);
  localparam logic [DIV_W-1:0] LAST    = DIV_W'(DIV - 1);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  // phase enables: falling phase mid period, rising phase at period end
  always_comb begin
    fall_en = (cnt == HALF_M1);
    rise_en = (cnt == LAST);
  end

  AST_PHASE_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
    rise_en |=> !rise_en); // R1
endmodule

// File: rtl/ohp_seq.sv
module ohp_seq
  import ohp_pkg::*;
#(
  parameter int BYTE_PERIOD = 10,
  parameter int FCNT_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall_en,
  input  logic              rise_en,
  output logic              en_d,
  output logic              frame_d,
  output logic              samp_first,
  output logic              samp_on,
  output logic              samp_last,
  output logic              valid_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [FCNT_W-1:0] frame_cnt_o
);
  localparam int SLOT_W = $clog2(BYTE_PERIOD);
  localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(BYTE_PERIOD - 1);
  localparam logic [SLOT_W-1:0] START_SLOT = SLOT_W'(BYTE_PERIOD - 2);
  localparam logic [SLOT_W-1:0] BIT_SLOTS  = SLOT_W'(BITS_PER_BYTE);
  localparam logic [SEL_W-1:0]  LAST_BYTE  = SEL_W'(POH_BYTES - 1);

  logic [SLOT_W-1:0] slot, slot_nxt;
  logic [SEL_W-1:0]  byte_idx, byte_nxt;

  always_comb begin
    if (slot == LAST_SLOT) begin
      slot_nxt = '0;
      byte_nxt = (byte_idx == LAST_BYTE) ? '0 : byte_idx + 1'b1;
    end else begin
      slot_nxt = slot + 1'b1;
      byte_nxt = byte_idx;
    end
    // strobe high for slots 0..7: leads the first bit by one period
    en_d       = (slot_nxt < BIT_SLOTS);
    frame_d    = en_d && (byte_nxt == '0);
    // bits live in slots 1..8
    samp_on    = rise_en && (slot != '0) && (slot <= BIT_SLOTS);
    samp_first = rise_en && (slot == SLOT_W'(1));
    samp_last  = rise_en && (slot == BIT_SLOTS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot        <= START_SLOT;
      byte_idx    <= LAST_BYTE;
      valid_o     <= 1'b0;
      sel_o       <= '0;
      frame_cnt_o <= '0;
    end else begin
      if (fall_en) begin
        slot     <= slot_nxt;
        byte_idx <= byte_nxt;
      end
      valid_o <= samp_last;
      if (samp_last) begin
        sel_o <= byte_idx;
        if (byte_idx == LAST_BYTE) frame_cnt_o <= frame_cnt_o + 1'b1;
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o); // R7
  AST_FCNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (valid_o && sel_o == LAST_BYTE && !$past(rst)) |-> frame_cnt_o == FCNT_W'($past(frame_cnt_o) + 1'b1)); // R8
  AST_FCNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(valid_o && sel_o == LAST_BYTE) |-> $stable(frame_cnt_o)); // R8
  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> sel_o <= LAST_BYTE); // R7
endmodule

// File: rtl/ohp_lane.sv
module ohp_lane
  import ohp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fall_en,
  input  logic       rise_en,
  input  logic       en_d,
  input  logic       frame_d,
  input  logic       samp_first,
  input  logic       samp_on,
  input  logic       samp_last,
  input  logic       ins_i,
  input  logic       din_i,
  input  logic [7:0] def_i,
  output logic       oh_clk_o,
  output logic       oh_en_o,
  output logic       oh_frame_o,
  output logic [7:0] byte_o,
  output logic       ovr_o
);
  logic [BITS_PER_BYTE-2:0] shreg;
  logic                     all_ins;
  logic                     take_ext;

  always_comb take_ext = all_ins && ins_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      oh_clk_o   <= 1'b0;
      oh_en_o    <= 1'b0;
      oh_frame_o <= 1'b0;
      shreg      <= '0;
      all_ins    <= 1'b0;
      byte_o     <= '0;
      ovr_o      <= 1'b0;
    end else begin
      if (rise_en)      oh_clk_o <= 1'b1;
      else if (fall_en) oh_clk_o <= 1'b0;
      if (fall_en) begin
        oh_en_o    <= en_d;
        oh_frame_o <= frame_d;
      end
      if (samp_on) begin
        shreg   <= samp_first ? {{(BITS_PER_BYTE-2){1'b0}}, din_i} : {shreg[BITS_PER_BYTE-3:0], din_i};
        all_ins <= samp_first ? ins_i : take_ext;
      end
      if (samp_last) begin
        ovr_o  <= take_ext;
        byte_o <= take_ext ? {shreg, din_i} : def_i;
      end
    end
  end

  AST_EN_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $rose(oh_en_o) |-> $fell(oh_clk_o)); // R2
  AST_FRAME_IN_EN: assert property (@(posedge clk) disable iff (rst)
    oh_frame_o |-> oh_en_o); // R3
  AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(samp_last) |-> ($stable(byte_o) && $stable(ovr_o))); // R7
  AST_SAMPLE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    samp_on |=> oh_clk_o); // R4
endmodule

// File: rtl/ohp_ins_port.sv
module ohp_ins_port
  import ohp_pkg::*;
#(
  parameter int NUM_CH      = 12,
  parameter int DIV         = 4,
  parameter int BYTE_PERIOD = 10,
  parameter int FCNT_W      = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CH-1:0]   ins_i,
  input  logic [NUM_CH-1:0]   din_i,
  input  logic [8*NUM_CH-1:0] def_i,
  output logic [NUM_CH-1:0]   oh_clk_o,
  output logic [NUM_CH-1:0]   oh_frame_o,
  output logic [NUM_CH-1:0]   oh_en_o,
  output logic [8*NUM_CH-1:0] byte_o,
  output logic [NUM_CH-1:0]   ovr_o,
  output logic                valid_o,
  output logic [3:0]          sel_o,
  output logic [FCNT_W-1:0]   frame_cnt_o
);
  // BYTE_PERIOD must be at least 9 (lead period plus eight bits); DIV even, >= 2
  logic fall_en, rise_en;
  logic en_d, frame_d, samp_first, samp_on, samp_last;

  ohp_clkdiv #(.DIV(DIV)) u_div (
    .clk(clk), .rst(rst), .fall_en(fall_en), .rise_en(rise_en)
  );

  ohp_seq #(.BYTE_PERIOD(BYTE_PERIOD), .FCNT_W(FCNT_W)) u_seq (
    .clk(clk), .rst(rst), .fall_en(fall_en), .rise_en(rise_en),
    .en_d(en_d), .frame_d(frame_d), .samp_first(samp_first),
    .samp_on(samp_on), .samp_last(samp_last), .valid_o(valid_o),
    .sel_o(sel_o), .frame_cnt_o(frame_cnt_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    ohp_lane u_lane (
      .clk(clk), .rst(rst), .fall_en(fall_en), .rise_en(rise_en),
      .en_d(en_d), .frame_d(frame_d), .samp_first(samp_first),
      .samp_on(samp_on), .samp_last(samp_last),
      .ins_i(ins_i[c]), .din_i(din_i[c]), .def_i(def_i[8*c +: 8]),
      .oh_clk_o(oh_clk_o[c]), .oh_en_o(oh_en_o[c]), .oh_frame_o(oh_frame_o[c]),
      .byte_o(byte_o[8*c +: 8]), .ovr_o(ovr_o[c])
    );
  end

  AST_OVR_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_o[0]) |-> valid_o); // R5
endmodule

// File: tb/tb_ohp_ins_port.sv
`timescale 1ns/1ps
module tb_ohp_ins_port;
  localparam int NCH = 12;
  localparam int DIV = 4;
  localparam int BP  = 10;
  localparam int FW  = 8;
  localparam int FRAME_CYC = 9 * BP * DIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0]   ins_i = '0;
  logic [NCH-1:0]   din_i = '0;
  logic [8*NCH-1:0] def_i = '0;
  logic [NCH-1:0]   oh_clk_o, oh_frame_o, oh_en_o, ovr_o;
  logic [8*NCH-1:0] byte_o;
  logic             valid_o;
  logic [3:0]       sel_o;
  logic [FW-1:0]    frame_cnt_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] ext [NCH][9];
  logic [7:0] msk [NCH][9];

  always #2 clk = ~clk;

  ohp_ins_port #(.NUM_CH(NCH), .DIV(DIV), .BYTE_PERIOD(BP), .FCNT_W(FW)) dut (
    .clk(clk), .rst(rst), .ins_i(ins_i), .din_i(din_i), .def_i(def_i),
    .oh_clk_o(oh_clk_o), .oh_frame_o(oh_frame_o), .oh_en_o(oh_en_o),
    .byte_o(byte_o), .ovr_o(ovr_o), .valid_o(valid_o), .sel_o(sel_o),
    .frame_cnt_o(frame_cnt_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] defv(input int ch, input int b);
    return 8'(((ch & 15) << 4) | (b & 15)) ^ 8'h5A;
  endfunction

  // one complete frame of external-side protocol plus result checks
  task automatic run_frame(input string tag_ins, input string tag_def);
    int k = 9;
    int b = 0;
    bit started = 0;
    int nvalid = 0;
    int guard = 0;
    logic pc = oh_clk_o[0];
    logic pe = oh_en_o[0];
    logic [FW-1:0] fc0 = '0;
    while (nvalid < 9 && guard < 3 * FRAME_CYC) begin
      @(negedge clk);
      guard++;
      if (pc && !oh_clk_o[0]) begin
        if (oh_en_o[0] && !pe) begin
          if (oh_frame_o[0]) begin started = 1; b = 0; fc0 = frame_cnt_o; end
          else if (started) b++;
          k = 0;
          if (started) for (int c = 0; c < NCH; c++) def_i[8*c +: 8] = defv(c, b);
        end else if (k < 9) k++;
        for (int c = 0; c < NCH; c++) begin
          if (started && k >= 1 && k <= 8) begin
            din_i[c] = ext[c][b][8-k];   // R4: MSB first
            ins_i[c] = msk[c][b][8-k];
          end else begin
            din_i[c] = 1'b0;
            ins_i[c] = 1'b0;
          end
        end
      end
      if (started && valid_o) begin
        chk("R7 byte index", 32'(sel_o), 32'(b));
        for (int c = 0; c < NCH; c++) begin
          if (msk[c][b] == 8'hFF) begin
            chk("R4 R5 override flag", 32'(ovr_o[c]), 32'd1);
            chk(tag_ins, 32'(byte_o[8*c +: 8]), 32'(ext[c][b]));
          end else begin
            chk("R6 override flag", 32'(ovr_o[c]), 32'd0);
            chk(tag_def, 32'(byte_o[8*c +: 8]), 32'(defv(c, b)));
          end
        end
        if (b == 8) chk("R8 frame counter step", 32'(frame_cnt_o), 32'(FW'(fc0 + 1'b1)));
        @(negedge clk);
        chk("R7 valid one cycle", 32'(valid_o), 32'd0);
        nvalid++;
      end
      pc = oh_clk_o[0];
      pe = oh_en_o[0];
    end
    chk("R7 nine results per frame", 32'(nvalid), 32'd9);
  endtask

  task automatic test_reset;
    rst = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10 clock", 32'(oh_clk_o), 32'd0);
    chk("R10 strobes", 32'({oh_en_o, oh_frame_o}), 32'd0);
    chk("R10 valid/sel", 32'({valid_o, sel_o}), 32'd0);
    chk("R10 frame count", 32'(frame_cnt_o), 32'd0);
    chk("R10 flags", 32'(ovr_o), 32'd0);
    chk("R10 bytes", 32'(byte_o[31:0]), 32'd0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 clock low after reset", 32'(oh_clk_o[0]), 32'd0);
  endtask

  task automatic test_strobes;
    int frame_hi = 0, en_hi = 0, en_rises = 1, bad_rise = 0, frame_rises = 1;
    int run = 0, bad_run = 0, mismatch = 0, fr_no_en = 0;
    logic pc, pe, pf;
    int guard = 0;
    pf = oh_frame_o[0];
    do begin
      pf = oh_frame_o[0];
      @(negedge clk);
      guard++;
    end while (!(oh_frame_o[0] && !pf) && guard < 2 * FRAME_CYC);
    pc = oh_clk_o[0]; pe = 1'b0; pf = 1'b0;
    // include the cycle of the first rise
    frame_hi = 1; en_hi = 1;
    pe = 1'b1; pf = 1'b1;
    for (int i = 1; i < FRAME_CYC; i++) begin
      @(negedge clk);
      if (oh_frame_o[0]) frame_hi++;
      if (oh_en_o[0]) en_hi++;
      if (oh_frame_o[0] && !oh_en_o[0]) fr_no_en++;
      if (oh_en_o[0] && !pe) begin
        en_rises++;
        if (!(pc && !oh_clk_o[0])) bad_rise++;
      end
      if (oh_frame_o[0] && !pf) frame_rises++;
      if (oh_clk_o[0] != pc) begin
        if (i > DIV && run != DIV / 2) bad_run++;
        run = 1;
      end else run++;
      if (oh_clk_o != {NCH{oh_clk_o[0]}} || oh_en_o != {NCH{oh_en_o[0]}} ||
          oh_frame_o != {NCH{oh_frame_o[0]}}) mismatch++;
      pc = oh_clk_o[0]; pe = oh_en_o[0]; pf = oh_frame_o[0];
    end
    chk("R1 clock half period", 32'(bad_run), 32'd0);
    chk("R2 strobe rises per frame", 32'(en_rises), 32'd9);
    chk("R2 strobe rises on falling edge", 32'(bad_rise), 32'd0);
    chk("R2 strobe high cycles", 32'(en_hi), 32'(9 * 8 * DIV));
    chk("R3 frame high cycles", 32'(frame_hi), 32'(8 * DIV));
    chk("R3 frame rises per frame", 32'(frame_rises), 32'd1);
    chk("R3 frame inside strobe", 32'(fr_no_en), 32'd0);
    chk("R9 timing equal on all channels", 32'(mismatch), 32'd0);
  endtask

  task automatic test_full_insert;
    for (int c = 0; c < NCH; c++)
      for (int b = 0; b < 9; b++) begin
        ext[c][b] = 8'(c * 17 + b * 29 + 8'h13);
        msk[c][b] = 8'hFF;
      end
    ext[0][0] = 8'h81; ext[1][0] = 8'h01; ext[2][0] = 8'hC8;
    run_frame("R4 R5 inserted byte", "R6 default byte");
  endtask

  task automatic test_no_insert;
    for (int c = 0; c < NCH; c++)
      for (int b = 0; b < 9; b++) begin
        ext[c][b] = 8'(~(c * 11 + b * 7));
        msk[c][b] = 8'h00;
      end
    run_frame("R5 inserted byte", "R6 default with no insert");
  endtask

  task automatic test_partial;
    for (int c = 0; c < NCH; c++)
      for (int b = 0; b < 9; b++) begin
        ext[c][b] = 8'(c * 5 + b * 3 + 8'hA1);
        msk[c][b] = ~(8'h01 << ((c + b) % 8));
      end
    run_frame("R5 inserted byte", "R6 default after dropped insert bit");
  endtask

  task automatic test_mixed;
    for (int c = 0; c < NCH; c++)
      for (int b = 0; b < 9; b++) begin
        ext[c][b] = 8'(c * 23 + b * 41 + 8'h3C);
        msk[c][b] = ((c + b) % 2 == 0) ? 8'hFF : (((c + b) % 3 == 0) ? 8'h7F : 8'h00);
      end
    run_frame("R9 R5 channel inserted byte", "R9 R6 channel default byte");
  endtask

  task automatic test_frame_counter;
    logic [FW-1:0] f0;
    f0 = frame_cnt_o;
    test_full_insert();
    test_full_insert();
    chk("R8 two frames counted", 32'(FW'(frame_cnt_o - f0)), 32'd2);
  endtask

  initial begin
    test_reset();
    test_strobes();
    test_full_insert();
    test_no_insert();
    test_partial();
    test_mixed();
    test_frame_counter();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule